// File: doc/BRIEF.md
# Configurable Dual/Single Decoder with Polarity Select

This block is an address decoder with two output groups of four lines each. A mode input picks one of two configurations. In dual mode the groups work as two independent 2-to-4 decoders. Each group has its own 2-bit address and its own pair of active-low enables. In single mode the two groups together form one 3-to-8 decoder. An extra top address bit chooses the group, the lower group is gated by its own enable pair, and the upper group is gated by the other enable pair.

Three polarity inputs set the active level. One select covers the lower group, one covers the upper group, and a common select is applied to both. The effective level of a group is the XOR of its own select with the common select: 1 means active-high and 0 means active-low. The decode function is the same for either level, and only the output is inverted.

A parameter can add one output register stage. While reset is held, and until the first clock edge after reset is released, the registered output shows the idle pattern for the polarity inputs as they currently stand.

Top module: `cfg_decoder`

## Requirements
- R1: With mode_i = 0 and both en_a_ni bits 0, z_o[3:0] has exactly one active bit, at index addr_a_i. addr_top_i has no effect on any output in this mode.
- R2: With mode_i = 0 and both en_b_ni bits 0, z_o[7:4] has exactly one active bit, at index 4 + addr_b_i.
- R3: The lower group z_o[3:0] shows its idle pattern whenever either en_a_ni bit is 1. The upper group z_o[7:4] shows its idle pattern whenever either en_b_ni bit is 1. This holds in both modes.
- R4: With mode_i = 1, the selected index is {addr_top_i, addr_a_i | addr_b_i}. When the group that owns that index is enabled, exactly one of the eight outputs is active.
- R5: The lower group is active-high when pol_a_i ^ pol_c_i = 1 and active-low when it is 0. The upper group uses pol_b_i ^ pol_c_i in the same way. Active-high means the selected bit is 1, the others are 0, and the idle pattern is all 0. Active-low is the complement: the selected bit is 0, the others are 1, and the idle pattern is all 1.
- R6: With REG_OUT = 0, z_o follows the inputs in the same cycle. With REG_OUT = 1, z_o shows the decode of the inputs sampled at the previous rising clock edge.
- R7: With REG_OUT = 1, while rst_ni is 0 and until the first rising edge after it is released, z_o equals the idle pattern for the current polarity inputs.
- R8: With mode_i = 1, the group that addr_top_i does not select shows its idle pattern. addr_top_i = 0 selects the lower group and addr_top_i = 1 selects the upper group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 0 = two 2-to-4 decoders, 1 = one 3-to-8 decoder |
| en_a_ni | input | 2 | Active-low enables of the lower group |
| en_b_ni | input | 2 | Active-low enables of the upper group |
| addr_a_i | input | SEL_W | Lower group address; low address bits in single mode |
| addr_top_i | input | 1 | Group select in single mode, ignored in dual mode |
| addr_b_i | input | SEL_W | Upper group address; OR'd into the low bits in single mode |
| pol_a_i | input | 1 | Polarity select of the lower group |
| pol_b_i | input | 1 | Polarity select of the upper group |
| pol_c_i | input | 1 | Common polarity select |
| z_o | output | 2*2**SEL_W | Decoded outputs, lower group in the low bits |

## Verification
The bench builds two instances, both with the default SEL_W = 2. One has REG_OUT = 1 and the other has REG_OUT = 0, and both are driven by the same stimulus. With the combinational instance, every one of the 8192 combinations of mode, enables, addresses and polarity inputs can be compared against the model in the same cycle. The registered instance makes the one-cycle latency and the polarity-dependent idle pattern under reset observable. It also shows that the output holds the previous result until the next clock edge.

// File: rtl/cfg_dec_pkg.sv
`timescale 1ns/1ps
package cfg_dec_pkg;
  localparam int unsigned NUM_GRP = 2;

  typedef enum logic {
    MODE_DUAL   = 1'b0,
    MODE_SINGLE = 1'b1
  } dec_mode_e;
endpackage

// File: rtl/cfg_dec_route.sv
`timescale 1ns/1ps
module cfg_dec_route
  import cfg_dec_pkg::*;
#(
  parameter int unsigned SEL_W = 2
) (
  input  logic                            mode_i,
  input  logic [1:0]                      en_a_ni,
  input  logic [1:0]                      en_b_ni,
  input  logic [SEL_W-1:0]                addr_a_i,
  input  logic                            addr_top_i,
  input  logic [SEL_W-1:0]                addr_b_i,
  output logic [NUM_GRP-1:0]              grp_en_o,
  output logic [NUM_GRP-1:0][SEL_W-1:0]   grp_sel_o
);
  logic             en_lo, en_hi;
  logic [SEL_W-1:0] merged;

  assign en_lo  = ~|en_a_ni;
  assign en_hi  = ~|en_b_ni;
  // tied-low b address leaves the single-mode index untouched
  assign merged = addr_a_i | addr_b_i;

  always_comb begin
    if (dec_mode_e'(mode_i) == MODE_SINGLE) begin
      grp_en_o[0]  = en_lo & ~addr_top_i;
      grp_en_o[1]  = en_hi &  addr_top_i;
      grp_sel_o[0] = merged;
      grp_sel_o[1] = merged;
    end else begin
      grp_en_o[0]  = en_lo;
      grp_en_o[1]  = en_hi;
      grp_sel_o[0] = addr_a_i;
      grp_sel_o[1] = addr_b_i;
    end
  end
endmodule

// File: rtl/cfg_dec_group.sv
`timescale 1ns/1ps
module cfg_dec_group #(
  parameter int unsigned SEL_W = 2,
  localparam int unsigned GRP_W = 1 << SEL_W
) (
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             act_high_i,
  output logic [GRP_W-1:0] z_o,
  output logic [GRP_W-1:0] idle_o
);
  logic [GRP_W-1:0] hot;

  always_comb begin
    hot = '0;
    if (en_i) hot[sel_i] = 1'b1;
  end

  assign z_o    = act_high_i ? hot : ~hot;
  assign idle_o = act_high_i ? '0 : '1;
endmodule

// File: rtl/cfg_dec_outreg.sv
`timescale 1ns/1ps
module cfg_dec_outreg #(
  parameter int unsigned W       = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  input  logic [W-1:0] idle_i,
  output logic [W-1:0] q_o
);
  if (REG_OUT) begin : g_reg
    logic         vld_q;
    logic [W-1:0] d_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q <= 1'b0;
        d_q   <= '0;
      end else begin
        vld_q <= 1'b1;
        d_q   <= d_i;
      end
    end
    // idle level follows live polarity until first capture
    assign q_o = vld_q ? d_q : idle_i;
  end else begin : g_comb
    logic unused_clk_rst;
    logic [W-1:0] unused_idle;
    assign unused_clk_rst = clk_i ^ rst_ni;
    assign unused_idle    = idle_i;
    assign q_o = d_i;
  end
endmodule

// File: rtl/cfg_decoder.sv
`timescale 1ns/1ps
module cfg_decoder
  import cfg_dec_pkg::*;
#(
  parameter int unsigned SEL_W   = 2,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned GRP_W  = 1 << SEL_W,
  localparam int unsigned OUT_W  = NUM_GRP * GRP_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  input  logic [1:0]       en_a_ni,
  input  logic [1:0]       en_b_ni,
  input  logic [SEL_W-1:0] addr_a_i,
  input  logic             addr_top_i,
  input  logic [SEL_W-1:0] addr_b_i,
  input  logic             pol_a_i,
  input  logic             pol_b_i,
  input  logic             pol_c_i,
  output logic [OUT_W-1:0] z_o
);
  logic [NUM_GRP-1:0]            grp_en;
  logic [NUM_GRP-1:0][SEL_W-1:0] grp_sel;
  logic [NUM_GRP-1:0]            act_high;
  logic [OUT_W-1:0]              z_d;
  logic [OUT_W-1:0]              idle;

  assign act_high[0] = pol_a_i ^ pol_c_i;
  assign act_high[1] = pol_b_i ^ pol_c_i;

  cfg_dec_route #(.SEL_W(SEL_W)) u_route (
    .mode_i     (mode_i),
    .en_a_ni    (en_a_ni),
    .en_b_ni    (en_b_ni),
    .addr_a_i   (addr_a_i),
    .addr_top_i (addr_top_i),
    .addr_b_i   (addr_b_i),
    .grp_en_o   (grp_en),
    .grp_sel_o  (grp_sel)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    cfg_dec_group #(.SEL_W(SEL_W)) u_group (
      .en_i       (grp_en[g]),
      .sel_i      (grp_sel[g]),
      .act_high_i (act_high[g]),
      .z_o        (z_d[g*GRP_W +: GRP_W]),
      .idle_o     (idle[g*GRP_W +: GRP_W])
    );
  end

  cfg_dec_outreg #(.W(OUT_W), .REG_OUT(REG_OUT)) u_outreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (z_d),
    .idle_i (idle),
    .q_o    (z_o)
  );
endmodule

// File: rtl/cfg_decoder_chk.sv
`timescale 1ns/1ps
module cfg_decoder_chk #(
  parameter int unsigned SEL_W   = 2,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned GRP_W  = 1 << SEL_W,
  localparam int unsigned OUT_W  = 2 * GRP_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode_i,
  input logic [1:0]       en_a_ni,
  input logic [1:0]       en_b_ni,
  input logic             addr_top_i,
  input logic             pol_a_i,
  input logic             pol_b_i,
  input logic             pol_c_i,
  input logic [OUT_W-1:0] z_d,
  input logic [OUT_W-1:0] z_o
);
  logic             hi_lo, hi_up;
  logic [GRP_W-1:0] idle_lo, idle_up;
  logic [OUT_W-1:0] idle_all;
  logic             seen_q;

  assign hi_lo    = pol_a_i ^ pol_c_i;
  assign hi_up    = pol_b_i ^ pol_c_i;
  assign idle_lo  = {GRP_W{~hi_lo}};
  assign idle_up  = {GRP_W{~hi_up}};
  assign idle_all = {idle_up, idle_lo};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  a_r1_dual_lo_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && !(|en_a_ni)) |-> $countones(z_d[GRP_W-1:0] ^ idle_lo) == 1);

  a_r2_dual_up_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && !(|en_b_ni)) |-> $countones(z_d[OUT_W-1:GRP_W] ^ idle_up) == 1);

  a_r3_lo_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|en_a_ni) |-> z_d[GRP_W-1:0] == idle_lo);

  a_r3_up_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|en_b_ni) |-> z_d[OUT_W-1:GRP_W] == idle_up);

  a_r4_single_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && !(|en_a_ni) && !(|en_b_ni)) |-> $countones(z_d ^ idle_all) == 1);

  a_r5_lo_at_most_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(z_d[GRP_W-1:0] ^ idle_lo) <= 1);

  a_r5_up_at_most_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(z_d[OUT_W-1:GRP_W] ^ idle_up) <= 1);

  a_r8_single_unselected_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i |-> (addr_top_i ? (z_d[GRP_W-1:0] == idle_lo) : (z_d[OUT_W-1:GRP_W] == idle_up)));

  if (REG_OUT) begin : g_lat
    a_r6_reg_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen_q |-> z_o == $past(z_d));
  end else begin : g_nolat
    a_r6_comb_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen_q |-> z_o == z_d);
  end
endmodule

bind cfg_decoder cfg_decoder_chk #(.SEL_W(SEL_W), .REG_OUT(REG_OUT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_i     (mode_i),
  .en_a_ni    (en_a_ni),
  .en_b_ni    (en_b_ni),
  .addr_top_i (addr_top_i),
  .pol_a_i    (pol_a_i),
  .pol_b_i    (pol_b_i),
  .pol_c_i    (pol_c_i),
  .z_d        (z_d),
  .z_o        (z_o)
);

// File: tb/cfg_decoder_bench.sv
`timescale 1ns/1ps
module cfg_decoder_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode = 1'b0;
  logic [1:0] en_a = 2'b11, en_b = 2'b11;
  logic [1:0] aa = '0, ab = '0;
  logic       a2 = 1'b0;
  logic       pa = 1'b1, pb = 1'b1, pc = 1'b0;
  logic [7:0] z_reg, z_cmb;
  logic [7:0] prev_exp;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  cfg_decoder #(.SEL_W(2), .REG_OUT(1'b1)) u_cfg_decoder (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .en_a_ni(en_a), .en_b_ni(en_b),
    .addr_a_i(aa), .addr_top_i(a2), .addr_b_i(ab),
    .pol_a_i(pa), .pol_b_i(pb), .pol_c_i(pc), .z_o(z_reg));

  cfg_decoder #(.SEL_W(2), .REG_OUT(1'b0)) u_cfg_decoder_comb (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .en_a_ni(en_a), .en_b_ni(en_b),
    .addr_a_i(aa), .addr_top_i(a2), .addr_b_i(ab),
    .pol_a_i(pa), .pol_b_i(pb), .pol_c_i(pc), .z_o(z_cmb));

  function automatic logic [7:0] idle_of(logic p_a, logic p_b, logic p_c);
    return {{4{~(p_b ^ p_c)}}, {4{~(p_a ^ p_c)}}};
  endfunction

  function automatic logic [7:0] model(logic m, logic [1:0] ea, logic [1:0] eb,
                                       logic [1:0] xa, logic x2, logic [1:0] xb,
                                       logic p_a, logic p_b, logic p_c);
    logic [7:0] hot = '0;
    logic [2:0] idx;
    if (!m) begin
      if (ea == 2'b00) hot[{1'b0, xa}] = 1'b1;
      if (eb == 2'b00) hot[{1'b1, xb}] = 1'b1;
    end else begin
      idx = {x2, xa | xb};
      if (!x2 && ea == 2'b00) hot[idx] = 1'b1;
      if ( x2 && eb == 2'b00) hot[idx] = 1'b1;
    end
    return hot ^ idle_of(p_a, p_b, p_c);
  endfunction

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic drive(logic m, logic [1:0] ea, logic [1:0] eb, logic [1:0] xa,
                       logic x2, logic [1:0] xb, logic p_a, logic p_b, logic p_c,
                       string tag);
    logic [7:0] exp;
    @(negedge clk);
    mode = m; en_a = ea; en_b = eb; aa = xa; a2 = x2; ab = xb; pa = p_a; pb = p_b; pc = p_c;
    exp = model(m, ea, eb, xa, x2, xb, p_a, p_b, p_c);
    #1;
    chk(tag, z_cmb, exp);
    chk("R6 hold before edge", z_reg, prev_exp);
    @(posedge clk);
    #1;
    chk({tag, " R6 registered"}, z_reg, exp);
    prev_exp = exp;
  endtask

  task automatic t_reset;
    for (int p = 0; p < 8; p++) begin
      {pa, pb, pc} = 3'(p);
      #1;
      chk("R7 idle in reset", z_reg, idle_of(pa, pb, pc));
    end
    @(negedge clk);
    mode = 1'b0; en_a = 2'b00; en_b = 2'b00; aa = 2'd2; ab = 2'd1;
    pa = 1'b0; pb = 1'b1; pc = 1'b0;
    rst_n = 1'b1;
    #1;
    chk("R7 idle after release", z_reg, idle_of(1'b0, 1'b1, 1'b0));
    @(posedge clk);
    #1;
    prev_exp = model(1'b0, 2'b00, 2'b00, 2'd2, 1'b0, 2'd1, 1'b0, 1'b1, 1'b0);
    chk("R6 first capture", z_reg, prev_exp);
  endtask

  task automatic t_dual;
    for (int i = 0; i < 32; i++)
      drive(1'b0, 2'b00, 2'b00, i[1:0], i[4], i[3:2], 1'b1, 1'b1, 1'b0, "R1 R2 dual decode");
    drive(1'b0, 2'b00, 2'b00, 2'd3, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, "R1 top bit low");
    drive(1'b0, 2'b00, 2'b00, 2'd3, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, "R1 top bit ignored");
  endtask

  task automatic t_enables;
    for (int m = 0; m < 2; m++)
      for (int e = 1; e < 16; e++)
        drive(m[0], e[1:0], e[3:2], 2'd1, 1'b0, 2'd2, 1'b1, 1'b1, 1'b0, "R3 enable gating");
    drive(1'b1, 2'b00, 2'b10, 2'd2, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, "R3 upper gated single");
  endtask

  task automatic t_single;
    for (int i = 0; i < 8; i++)
      drive(1'b1, 2'b00, 2'b00, i[1:0], i[2], 2'd0, 1'b0, 1'b0, 1'b1, "R4 single decode");
    drive(1'b1, 2'b00, 2'b00, 2'd1, 1'b1, 2'd2, 1'b0, 1'b0, 1'b1, "R4 b bits OR'd");
    drive(1'b1, 2'b00, 2'b00, 2'd2, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, "R8 upper idle active-low");
    drive(1'b1, 2'b00, 2'b00, 2'd0, 1'b1, 2'd0, 1'b1, 1'b0, 1'b1, "R8 lower idle mixed pol");
  endtask

  task automatic t_polarity;
    for (int p = 0; p < 8; p++) begin
      drive(1'b0, 2'b00, 2'b00, 2'd2, 1'b0, 2'd3, p[2], p[1], p[0], "R5 polarity dual");
      drive(1'b1, 2'b00, 2'b00, 2'd1, p[0], 2'd0, p[2], p[1], p[0], "R5 polarity single");
    end
  endtask

  task automatic t_sweep;
    for (int v = 0; v < 8192; v++)
      drive(v[12], v[11:10], v[9:8], v[7:6], v[5], v[4:3], v[2], v[1], v[0], "R5 sweep");
  endtask

  initial begin
    prev_exp = '0;
    repeat (3) @(posedge clk);
    t_reset();
    t_dual();
    t_enables();
    t_single();
    t_polarity();
    t_sweep();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule